// File: doc/BRIEF.md
# Write-Protected Power Mode Controller

This block keeps an 8-bit power mode control register and turns its fields into clock-enable pulses for the rest of a processor subsystem. The system clock enable can be divided by any power of two from 1 to 32768. The division applies only while the PLL reports that it is running. A second enable feeds a baud-rate generator and runs at the full rate or at half rate. A stop request either parks the block in standby, parks it in a generic stop state, or is ignored. The choice depends on the low-power select field. A wake input brings the block back to the running state after a fixed delay.

Software writes the register through a simple bus made of an address match, a write strobe, write data and read data. Setting the protect bit freezes the register until the next reset. The write that sets the bit still takes effect in full. A new divide ratio can be written at any time. It is adopted only at the end of a complete period of the ratio in force, so no enable interval is ever cut short.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The register reads back on `reg_rdata` in the cycle after it is written. Its fields are: bit 7 is the protect flag, bits 6:3 are the divide exponent N, bit 2 is the baud half-rate select, and bits 1:0 are the low-power select.
- R2: Reset clears every register bit to 0, and a write that follows reset is accepted.
- R3: A write that sets bit 7 stores all 8 written bits. Every later write leaves the register unchanged until reset.
- R4: With `pll_on` high and the block running, `sys_ce` is high for one cycle in every 2^N cycles, for each N from 0 to 15.
- R5: A new exponent is adopted only in the cycle in which the current ratio's pulse fires. Every interval between pulses therefore equals either the whole old period or the whole new period.
- R6: With `pll_on` low and the block running, `sys_ce` is high in every cycle.
- R7: With bit 2 at 0, `brg_ce` is high in every cycle. With bit 2 at 1, it is high in every second cycle.
- R8: A stop request made while running, with low-power select 01, makes `standby` go high in the next cycle. `sys_ce` then stays low for as long as the block is not running.
- R9: A wake pulse seen in standby or in stop starts a recovery of 4 cycles. The running state returns 5 cycles after the wake edge, and `sys_ce` resumes one cycle after that.
- R10: A stop request with select 00 is ignored. A stop request with select 10 or 11 raises `stopped`, which holds until a wake pulse arrives. Wake pulses and stop requests are ignored in states where they do not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Address match for the control register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| pll_on | input | 1 | PLL running; allows division |
| stop_req | input | 1 | Request to enter a low-power state |
| wake | input | 1 | Wake-up event |
| sys_ce | output | 1 | System clock enable pulse |
| brg_ce | output | 1 | Baud-rate generator clock enable |
| standby | output | 1 | Block is in standby |
| stopped | output | 1 | Block is in the generic stop state |

## Verification
The assertions assume that `stop_req` and `wake` are single-cycle pulses that arrive only in a running or parked state respectively. They also assume that no reset occurs inside a recovery window that a property is still watching. The stimulus drives every control input as a one-cycle pulse one time unit after a rising edge. It waits out each recovery before it issues the next request. It changes the divide exponent at arbitrary points in a period, so that both the old and the new ratio are exercised.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DF_W  = 4;
  localparam int CNT_W = (1 << DF_W) - 1;

  typedef enum logic [1:0] {
    LP_RUN     = 2'd0,
    LP_STANDBY = 2'd1,
    LP_STOP    = 2'd2,
    LP_WAKE    = 2'd3
  } lp_state_t;

  typedef struct packed {
    logic            lock;
    logic [DF_W-1:0] df;
    logic            brg_half;
    logic [1:0]      lpm;
  } ctl_t;

  localparam logic [1:0] LPM_IGNORE  = 2'b00;
  localparam logic [1:0] LPM_STANDBY = 2'b01;
endpackage

// File: rtl/pmc_ctlreg.sv
module pmc_ctlreg
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctl_t       ctl
);
  // The lock bit, once set, blocks any further update until reset.
  always_ff @(posedge clk) begin
    if (rst)
      ctl <= '0;
    else if (sel && wr && !ctl.lock)
      ctl <= ctl_t'(wdata);
  end
endmodule

// File: rtl/pmc_sysdiv.sv
module pmc_sysdiv #(
  parameter int DF_W  = 4,
  parameter int CNT_W = (1 << DF_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DF_W-1:0] df,
  input  logic            pll_on,
  input  logic            run,
  output logic            sys_ce
);
  logic [CNT_W-1:0] cnt;
  logic [DF_W-1:0]  df_act;
  logic [CNT_W-1:0] mask;
  logic             pulse;

  // Terminal count: the low df_act bits set, the rest clear.
  assign mask  = {CNT_W{1'b1}} >> (CNT_W - int'(df_act));
  assign pulse = (cnt == mask);

  // The counter restarts at every pulse, and the new ratio is loaded only
  // there, so each period is complete at one ratio or the other.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      df_act <= '0;
      sys_ce <= 1'b0;
    end else begin
      if (pulse) begin
        cnt    <= '0;
        df_act <= df;
      end else begin
        cnt <= cnt + 1'b1;
      end
      sys_ce <= run && (pll_on ? pulse : 1'b1);
    end
  end
endmodule

// File: rtl/pmc_brgdiv.sv
module pmc_brgdiv (
  input  logic clk,
  input  logic rst,
  input  logic half,
  output logic brg_ce
);
  logic tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog    <= 1'b0;
      brg_ce <= 1'b0;
    end else begin
      tog    <= ~tog;
      brg_ce <= half ? tog : 1'b1;
    end
  end
endmodule

// File: rtl/pmc_lowpower.sv
module pmc_lowpower
  import pmc_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lpm,
  input  logic       stop_req,
  input  logic       wake,
  output logic       run,
  output logic       standby,
  output logic       stopped
);
  localparam int WC_W = $clog2(WAKE_CYC + 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(WAKE_CYC - 1);

  lp_state_t       st;
  logic [WC_W-1:0] wc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= LP_RUN;
      wc <= '0;
    end else begin
      unique case (st)
        LP_RUN: begin
          if (stop_req) begin
            if (lpm == LPM_STANDBY)
              st <= LP_STANDBY;
            else if (lpm != LPM_IGNORE)
              st <= LP_STOP;
          end
        end
        LP_STANDBY, LP_STOP: begin
          if (wake) begin
            st <= LP_WAKE;
            wc <= '0;
          end
        end
        LP_WAKE: begin
          if (wc == WC_LAST)
            st <= LP_RUN;
          else
            wc <= wc + 1'b1;
        end
        default: st <= LP_RUN;
      endcase
    end
  end

  assign run     = (st == LP_RUN);
  assign standby = (st == LP_STANDBY);
  assign stopped = (st == LP_STOP);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       pll_on,
  input  logic       stop_req,
  input  logic       wake,
  output logic       sys_ce,
  output logic       brg_ce,
  output logic       standby,
  output logic       stopped
);
  ctl_t ctl;
  logic run_w;

  pmc_ctlreg u_reg (
    .clk   (clk),
    .rst   (rst),
    .sel   (reg_sel),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .ctl   (ctl)
  );

  pmc_lowpower #(.WAKE_CYC(WAKE_CYC)) u_lp (
    .clk      (clk),
    .rst      (rst),
    .lpm      (ctl.lpm),
    .stop_req (stop_req),
    .wake     (wake),
    .run      (run_w),
    .standby  (standby),
    .stopped  (stopped)
  );

  pmc_sysdiv #(.DF_W(DF_W), .CNT_W(CNT_W)) u_sys (
    .clk    (clk),
    .rst    (rst),
    .df     (ctl.df),
    .pll_on (pll_on),
    .run    (run_w),
    .sys_ce (sys_ce)
  );

  pmc_brgdiv u_brg (
    .clk    (clk),
    .rst    (rst),
    .half   (ctl.brg_half),
    .brg_ce (brg_ce)
  );

  assign reg_rdata = ctl;
endmodule

// File: rtl/pmc_checks.sv
module pmc_checks (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       pll_on,
  input logic       stop_req,
  input logic       wake,
  input logic [7:0] reg_rdata,
  input logic       sys_ce,
  input logic       brg_ce,
  input logic       standby,
  input logic       stopped
);
  // R3: once locked the register never changes
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rdata[7]) |-> reg_rdata == $past(reg_rdata));

  // R6: undivided when the PLL is off
  p_pll_off_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !pll_on) |=> sys_ce);

  // R7: full-rate baud enable
  p_brg_full_r7: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[2] |=> brg_ce);

  // R8: standby entry
  p_standby_entry_r8: assert property (@(posedge clk) disable iff (rst)
    (run && stop_req && reg_rdata[1:0] == 2'b01) |=> standby);

  // R8: no enable while parked
  p_standby_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (standby || stopped) |=> !sys_ce);

  // R9: recovery is not early and not late
  p_wake_early_r9: assert property (@(posedge clk) disable iff (rst)
    ((standby || stopped) && wake) |-> ##4 !run);
  p_wake_late_r9: assert property (@(posedge clk) disable iff (rst)
    ((standby || stopped) && wake) |-> ##5 run);

  // R10: select 00 ignores the request; parked states are exclusive
  p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (run && stop_req && reg_rdata[1:0] == 2'b00) |=> (!standby && !stopped));
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(standby && stopped));
endmodule

bind pwr_mode_ctrl pmc_checks u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run_w),
  .pll_on    (pll_on),
  .stop_req  (stop_req),
  .wake      (wake),
  .reg_rdata (reg_rdata),
  .sys_ce    (sys_ce),
  .brg_ce    (brg_ce),
  .standby   (standby),
  .stopped   (stopped)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pll_on = 1'b1, stop_req = 1'b0, wake = 1'b0;
  logic       sys_ce, brg_ce, standby, stopped;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl dut (.*);

  // Behavioural reference model, advanced on each rising edge.
  int  m_ctl, m_cnt, m_dfa, m_st, m_wc, m_per;
  bit  m_tog, m_sys, m_brg, m_pulse, m_nsys;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctl = 0; m_cnt = 0; m_dfa = 0; m_st = 0; m_wc = 0;
      m_tog = 0; m_sys = 0; m_brg = 0;
    end else begin
      m_per   = 1 << m_dfa;
      m_pulse = (m_cnt == m_per - 1);
      m_nsys  = (m_st == 0) && (pll_on ? m_pulse : 1'b1);
      m_brg   = m_ctl[2] ? m_tog : 1'b1;
      m_tog   = !m_tog;
      if (m_pulse) begin m_cnt = 0; m_dfa = (m_ctl >> 3) & 15; end
      else m_cnt++;
      case (m_st)
        0: if (stop_req) begin
             if ((m_ctl & 3) == 1) m_st = 1;
             else if ((m_ctl & 3) != 0) m_st = 2;
           end
        1, 2: if (wake) begin m_st = 3; m_wc = 0; end
        default: if (m_wc == 3) m_st = 0; else m_wc++;
      endcase
      m_sys = m_nsys;
      if (reg_sel && reg_wr && !m_ctl[7]) m_ctl = reg_wdata;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 R2 R3 rdata", reg_rdata, m_ctl & 8'hFF);
    chk("R4 R5 R6 R8 sys_ce", sys_ce, m_sys);
    chk("R7 brg_ce", brg_ce, m_brg);
    chk("R8 R9 standby", standby, m_st == 1);
    chk("R9 R10 stopped", stopped, m_st == 2);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic pulse_stop;
    stop_req = 1'b1; step(1); stop_req = 1'b0;
  endtask

  task automatic pulse_wake;
    wake = 1'b1; step(1); wake = 1'b0;
  endtask

  // R4: measure the gap between pulses independently for a given N
  task automatic gap_check(input int n);
    int last, gaps;
    last = -1; gaps = 0;
    while (gaps < 3) begin
      @(negedge clk);
      if (sys_ce) begin
        if (last >= 0) begin
          chk("R4 gap", cyc - last, 1 << n);
          gaps++;
        end
        last = cyc;
      end
    end
    step(1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R2 reset value", reg_rdata, 0);
    step(5);
    // R1 R2: fields and readback
    wr(8'h08);
    @(negedge clk); chk("R1 readback", reg_rdata, 8'h08);
    gap_check(1);
    // R5: change ratio mid-period
    step(3); wr(8'h18); step(37);
    gap_check(3);
    wr(8'h10); step(2); gap_check(2);
    wr(8'h00); gap_check(0);
    wr(8'h28); step(7); gap_check(5);
    // R6: PLL off gives every-cycle enable
    pll_on = 1'b0; step(20); pll_on = 1'b1; step(40);
    // R7: baud half rate
    wr(8'h04); step(20); wr(8'h00); step(5);
    // R8 R9: standby and wake
    wr(8'h09); step(3);
    pulse_stop;
    @(negedge clk); chk("R8 standby", standby, 1);
    step(15);
    pll_on = 1'b0; step(5);
    pulse_wake;
    step(12);
    pll_on = 1'b1;
    // R10: select 00 ignored, wake ignored while running
    wr(8'h08); step(2);
    pulse_stop; @(negedge clk); chk("R10 ignored", standby | stopped, 0);
    pulse_wake; step(6);
    // R10: generic stop held until wake
    wr(8'h0A); step(2);
    pulse_stop; step(30);
    @(negedge clk); chk("R10 stop held", stopped, 1);
    pulse_stop; step(3);
    pulse_wake; step(10);
    wr(8'h0B); pulse_stop; step(4); pulse_wake; step(10);
    // R4: largest ratio
    wr(8'h78); step(2);
    gap_check(15);
    // R3: locking write takes effect, then writes are ignored
    wr(8'h9D);
    @(negedge clk); chk("R3 lock write", reg_rdata, 8'h9D);
    step(2);
    wr(8'h00); step(1); wr(8'h42);
    @(negedge clk); chk("R3 locked", reg_rdata, 8'h9D);
    step(10);
    // R2: reset clears the lock
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    wr(8'h30);
    @(negedge clk); chk("R2 writable", reg_rdata, 8'h30);
    step(30);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule